// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

This block keeps calendar time: seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. A one-second pulse from outside the block advances it. A second bank of the same seven fields holds an alarm time. An alarm control byte selects which fields take part in the comparison. When every selected field matches the live time, the block raises a pending flag and drives its interrupt line.

Software reaches all of this through a flat byte-addressed register port. Writes take effect on the clock edge, and reads are combinational. A run/stop bit freezes the counter so that software can load a new time. A firing alarm disarms itself by clearing its own control byte. The pending flag stays set until the host writes a one to it. A three-bit debounce setting is stored and returned on reads and has no other effect. The leap rule is a simple one: every year divisible by four is a leap year, except year 0.

Top module: `cal_rtc_top`

## Requirements
- R1: After reset, the time bank reads year 0, month 1, day of month 1, and zero for weekday, hour, minute and second. The alarm bank reads all zero. The control register at 0x20 reads 1 (stopped). The alarm control at 0x7C, the status at 0x30 and the debounce at 0x2C read 0. `alarm_irq` is low.
- R2: While bit 0 of the register at 0x20 is 1, tick pulses leave every time field unchanged. Writing 0 to that bit lets ticks advance the counter, and the register reads back the bit written.
- R3: Each tick advances the seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry a day.
- R4: The weekday field advances on every day carry and wraps from 6 to 0.
- R5: On a day carry, day of month wraps to 1 after the last day of the month, and otherwise increments. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is a nonzero multiple of 4 and 28 days otherwise, so year 0 gets 28. All other months have 31 days.
- R6: When day of month wraps, month advances. Month 12 wraps to 1 and carries a year. Year 99 wraps to 0.
- R7: Field f of bank b sits at byte address 0x40 + 4*f + 0x20*b. Bank 0 is live time and bank 1 is the alarm. Field indices are: 0 year, 1 month, 2 day of month, 3 weekday, 4 hour, 5 minute, 6 second. Each field stores and returns the low 7 bits written. A write to the time bank in the same cycle as a tick replaces that field, and the tick is dropped for that cycle.
- R8: The register at 0x2C stores bits [2:0] of a write and reads 0 in bits [7:3].
- R9: While bit 0 of 0x7C is 1, a match fires the alarm. A match means every field f whose bit f+1 of 0x7C is 1 equals the live field. On the clock edge after the match, bit 4 of 0x30 becomes 1, `alarm_irq` rises, and 0x7C becomes 0.
- R10: Writing a value with bit 4 set to 0x30 clears the pending flag and drops `alarm_irq`. Writing a value with bit 4 clear leaves the flag set.
- R11: With bit 0 of 0x7C clear, a full match never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm pending interrupt |

## Verification
Register writes and counter steps become visible one edge after the strobe or tick. The bench therefore drives on the falling edge and reads back on the next falling edge. The alarm compare looks at the counter value after that step, and the pending flag registers one edge later again. So the bench first confirms that `alarm_irq` is still low right after the matching tick, and only one cycle later checks that it is high and that the control byte has cleared. The calendar sweep loads the last second of the month for every month of every year. After one tick it compares the carried fields with values the bench computes arithmetically.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int FIELD_W    = 7;
   localparam int NUM_FIELDS = 7;

   localparam int F_YEAR = 0;
   localparam int F_MON  = 1;
   localparam int F_DOM  = 2;
   localparam int F_DOW  = 3;
   localparam int F_HOUR = 4;
   localparam int F_MIN  = 5;
   localparam int F_SEC  = 6;

   localparam logic [7:0] OFF_CTRL  = 8'h20;
   localparam logic [7:0] OFF_DEB   = 8'h2C;
   localparam logic [7:0] OFF_STAT  = 8'h30;
   localparam logic [7:0] OFF_ALCTL = 8'h7C;
   localparam int         PEND_BIT  = 4;

   typedef logic [FIELD_W-1:0] fld_t;
   typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] bank_t;

   // days in a month; year 0 of the century is deliberately non-leap
   function automatic fld_t month_days(input fld_t mon, input fld_t yr);
      logic leap;
      leap = (yr[1:0] == 2'b00) && (yr != '0);
      case (mon)
         7'd2:                    return leap ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
         default:                 return 7'd31;
      endcase
   endfunction
endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
   import cal_pkg::*;
#(
   parameter int YEAR_MAX = 99
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   run,
   input  logic                   wr_en,
   input  logic [2:0]             wr_idx,
   input  fld_t                   wr_val,
   output bank_t                  now_o
);
   localparam fld_t YMAX = fld_t'(YEAR_MAX);

   generate
      if (YEAR_MAX < 1 || YEAR_MAX >= (1 << FIELD_W)) begin : g_bad_year
         $error("YEAR_MAX out of field range");
      end
   endgenerate

   bank_t cur, nxt;
   logic  step, sec_wrap, min_wrap, hour_wrap, dom_wrap, mon_wrap;
   fld_t  mlen;

   assign step      = tick & run & ~wr_en;
   assign mlen      = month_days(cur[F_MON], cur[F_YEAR]);
   assign sec_wrap  = cur[F_SEC]  >= 7'd59;
   assign min_wrap  = sec_wrap  & (cur[F_MIN]  >= 7'd59);
   assign hour_wrap = min_wrap  & (cur[F_HOUR] >= 7'd23);
   assign dom_wrap  = hour_wrap & (cur[F_DOM]  >= mlen);
   assign mon_wrap  = dom_wrap  & (cur[F_MON]  >= 7'd12);

   always_comb begin
      nxt = cur;
      nxt[F_SEC] = sec_wrap ? '0 : cur[F_SEC] + 7'd1;
      if (sec_wrap)
         nxt[F_MIN] = min_wrap ? '0 : cur[F_MIN] + 7'd1;
      if (min_wrap)
         nxt[F_HOUR] = hour_wrap ? '0 : cur[F_HOUR] + 7'd1;
      if (hour_wrap) begin
         nxt[F_DOW] = (cur[F_DOW] >= 7'd6) ? '0 : cur[F_DOW] + 7'd1;
         nxt[F_DOM] = dom_wrap ? 7'd1 : cur[F_DOM] + 7'd1;
      end
      if (dom_wrap)
         nxt[F_MON] = mon_wrap ? 7'd1 : cur[F_MON] + 7'd1;
      if (mon_wrap)
         nxt[F_YEAR] = (cur[F_YEAR] >= YMAX) ? '0 : cur[F_YEAR] + 7'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur         <= '0;
         cur[F_MON]  <= 7'd1;
         cur[F_DOM]  <= 7'd1;
      end else if (wr_en) begin
         for (int f = 0; f < NUM_FIELDS; f++)
            if (wr_idx == f[2:0]) cur[f] <= wr_val;
      end else if (step) begin
         cur <= nxt;
      end
   end

   assign now_o = cur;

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(cur));                                    // R2
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cur[F_SEC] == 7'd59) |=> (cur[F_SEC] == '0));                 // R3
   AST_DOM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && hour_wrap) |=> (cur[F_DOM] != '0));                           // R5
   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mon_wrap && cur[F_YEAR] == YMAX) |=> (cur[F_YEAR] == '0));    // R6
endmodule

// File: rtl/cal_alarm_bank.sv
module cal_alarm_bank
   import cal_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2:0]             wr_idx,
   input  fld_t                   wr_val,
   input  bank_t                  now_i,
   input  logic                   arm,
   input  logic [NUM_FIELDS-1:0]  sel,
   output bank_t                  alm_o,
   output logic                   fire
);
   bank_t                 alm;
   logic [NUM_FIELDS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm <= '0;
      end else if (wr_en) begin
         for (int f = 0; f < NUM_FIELDS; f++)
            if (wr_idx == f[2:0]) alm[f] <= wr_val;
      end
   end

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
         assign hit[f] = ~sel[f] | (alm[f] == now_i[f]);
      end
   endgenerate

   assign fire  = arm & (&hit);
   assign alm_o = alm;
endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
   import cal_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int DEB_W    = 3,
   parameter int YEAR_MAX = 99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              alarm_irq
);
   generate
      if (ADDR_W < 8)  begin : g_bad_addr $error("ADDR_W must be at least 8"); end
      if (DATA_W < 8)  begin : g_bad_data $error("DATA_W must be at least 8"); end
      if (DEB_W < 1 || DEB_W > 8) begin : g_bad_deb $error("DEB_W must be 1..8"); end
   endgenerate

   logic       hi_ok;
   logic [7:0] a8;

   generate
      if (ADDR_W > 8) begin : g_hi
         assign hi_ok = ~|reg_addr[ADDR_W-1:8];
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign a8 = reg_addr[7:0];

   logic       fld_hit, bank_sel, wr_time, wr_alm;
   logic [2:0] fidx;
   logic       wr_ctrl, wr_deb, wr_stat, wr_alctl;

   assign fld_hit  = hi_ok & (a8[7:6] == 2'b01) & (a8[1:0] == 2'b00) & (a8[4:2] != 3'b111);
   assign bank_sel = a8[5];
   assign fidx     = a8[4:2];
   assign wr_time  = reg_wr & fld_hit & ~bank_sel;
   assign wr_alm   = reg_wr & fld_hit &  bank_sel;
   assign wr_ctrl  = reg_wr & hi_ok & (a8 == OFF_CTRL);
   assign wr_deb   = reg_wr & hi_ok & (a8 == OFF_DEB);
   assign wr_stat  = reg_wr & hi_ok & (a8 == OFF_STAT);
   assign wr_alctl = reg_wr & hi_ok & (a8 == OFF_ALCTL);

   logic             stop_q, pend_q, fire;
   logic [DEB_W-1:0] deb_q;
   logic [7:0]       alctl_q;
   bank_t            now_b, alm_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q  <= 1'b1;
         deb_q   <= '0;
         alctl_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (wr_ctrl) stop_q <= reg_wdata[0];
         if (wr_deb)  deb_q  <= reg_wdata[DEB_W-1:0];
         if (fire)          alctl_q <= '0;
         else if (wr_alctl) alctl_q <= reg_wdata[7:0];
         if (fire)                             pend_q <= 1'b1;
         else if (wr_stat && reg_wdata[PEND_BIT]) pend_q <= 1'b0;
      end
   end

   cal_time_core #(.YEAR_MAX(YEAR_MAX)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (sec_tick),
      .run    (~stop_q),
      .wr_en  (wr_time),
      .wr_idx (fidx),
      .wr_val (reg_wdata[FIELD_W-1:0]),
      .now_o  (now_b)
   );

   cal_alarm_bank u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_alm),
      .wr_idx (fidx),
      .wr_val (reg_wdata[FIELD_W-1:0]),
      .now_i  (now_b),
      .arm    (alctl_q[0]),
      .sel    (alctl_q[7:1]),
      .alm_o  (alm_b),
      .fire   (fire)
   );

   logic [7:0] rd8;

   always_comb begin
      rd8 = '0;
      if (fld_hit) begin
         for (int f = 0; f < NUM_FIELDS; f++)
            if (fidx == f[2:0]) rd8 = {1'b0, bank_sel ? alm_b[f] : now_b[f]};
      end else if (hi_ok) begin
         case (a8)
            OFF_CTRL:  rd8 = {7'b0, stop_q};
            OFF_DEB:   rd8 = 8'(deb_q);
            OFF_STAT:  rd8 = 8'(pend_q) << PEND_BIT;
            OFF_ALCTL: rd8 = alctl_q;
            default:   rd8 = '0;
         endcase
      end
   end

   assign reg_rdata = DATA_W'(rd8);
   assign alarm_irq = pend_q;

   AST_FIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (alctl_q == '0));                                             // R9
   AST_FIRE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> alarm_irq);                                                   // R9
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[PEND_BIT] && !fire) |=> !alarm_irq);             // R10
   AST_ARM_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(alctl_q[0]));                                  // R11
endmodule

// File: tb/tb_cal_rtc_top.sv
module tb_cal_rtc_top;
   localparam int HALF = 10;

   logic       clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   wire  [7:0] reg_rdata;
   wire        alarm_irq;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #HALF clk = ~clk;

   cal_rtc_top dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alarm_irq(alarm_irq)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int fa(input int b, input int f);
      return 'h40 + 4 * f + 'h20 * b;
   endfunction

   function automatic int mdays(input int m, input int y);
      if (m == 2) return (y % 4 == 0 && y != 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic wr(input int a, input int d);
      reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = 8'(a);
      #1 v = int'(reg_rdata);
   endtask

   task automatic pulse();
      sec_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic set_time(input int y, input int mo, input int d, input int w,
                           input int h, input int mi, input int s);
      wr(fa(0,0), y); wr(fa(0,1), mo); wr(fa(0,2), d); wr(fa(0,3), w);
      wr(fa(0,4), h); wr(fa(0,5), mi); wr(fa(0,6), s);
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int f = 0; f < 7; f++) begin
         rd(fa(0,f), v); check("R1 time field", v, (f == 1 || f == 2) ? 1 : 0);
         rd(fa(1,f), v); check("R1 alarm field", v, 0);
      end
      rd('h20, v); check("R1 ctrl", v, 1);
      rd('h7C, v); check("R1 alctl", v, 0);
      rd('h30, v); check("R1 status", v, 0);
      rd('h2C, v); check("R1 debounce", v, 0);
      check("R1 irq", int'(alarm_irq), 0);

      // R2 stopped counter holds
      set_time(5, 3, 10, 2, 12, 34, 56);
      repeat (4) pulse();
      rd(fa(0,6), v); check("R2 sec held", v, 56);
      wr('h20, 0);
      rd('h20, v); check("R2 ctrl readback", v, 0);
      pulse();
      rd(fa(0,6), v); check("R2 sec runs", v, 57);

      // R3 minute carry without hour carry
      wr(fa(0,6), 59); pulse();
      rd(fa(0,6), v); check("R3 sec wrap", v, 0);
      rd(fa(0,5), v); check("R3 min carry", v, 35);
      rd(fa(0,4), v); check("R3 hour kept", v, 12);

      // R7 write in tick cycle wins, tick dropped
      reg_addr = 8'(fa(0,6)); reg_wdata = 8'd40; reg_wr = 1'b1; sec_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; sec_tick = 1'b0;
      rd(fa(0,6), v); check("R7 write beats tick", v, 40);
      rd(fa(0,5), v); check("R7 min unchanged", v, 35);
      wr(fa(1,4), 'hFF);
      rd(fa(1,4), v); check("R7 7-bit store", v, 'h7F);
      rd(fa(0,4), v); check("R7 bank separation", v, 12);

      // R8 debounce field
      wr('h2C, 'hFF);
      rd('h2C, v); check("R8 debounce mask", v, 7);
      wr('h2C, 'h05);
      rd('h2C, v); check("R8 debounce value", v, 5);

      // R5 explicit leap cases
      set_time(4, 2, 28, 0, 23, 59, 59); pulse();
      rd(fa(0,2), v); check("R5 leap day", v, 29);
      set_time(0, 2, 28, 0, 23, 59, 59); pulse();
      rd(fa(0,2), v); check("R5 year0 not leap dom", v, 1);
      rd(fa(0,1), v); check("R5 year0 not leap mon", v, 3);

      // R3 R4 R5 R6 sweep: last second of each month of each year
      for (int y = 0; y < 100; y++) begin
         for (int m = 1; m <= 12; m++) begin
            int w;
            w = (y + m) % 7;
            set_time(y, m, mdays(m, y), w, 23, 59, 59);
            pulse();
            rd(fa(0,2), v); check("R5 dom wrap", v, 1);
            rd(fa(0,1), v); check("R6 month", v, (m % 12) + 1);
            rd(fa(0,0), v); check("R6 year", v, (m == 12) ? ((y + 1) % 100) : y);
            rd(fa(0,3), v); check("R4 weekday", v, (w + 1) % 7);
            rd(fa(0,4), v); check("R3 hour wrap", v, 0);
         end
      end

      // R9 alarm on h:m:s, others unselected
      set_time(7, 6, 15, 1, 10, 20, 30);
      wr(fa(1,4), 10); wr(fa(1,5), 20); wr(fa(1,6), 31); wr(fa(1,0), 0);
      wr('h7C, 'hE1);
      check("R9 no early fire", int'(alarm_irq), 0);
      pulse();
      check("R9 irq not before compare edge", int'(alarm_irq), 0);
      @(negedge clk);
      check("R9 irq raised", int'(alarm_irq), 1);
      rd('h30, v); check("R9 pending bit4", v, 'h10);
      rd('h7C, v); check("R9 self disarm", v, 0);

      // R10 write-one-to-clear
      wr('h30, 'h00);
      check("R10 write zero ignored", int'(alarm_irq), 1);
      wr('h30, 'h10);
      check("R10 cleared", int'(alarm_irq), 0);
      rd('h30, v); check("R10 status zero", v, 0);

      // R11 disarmed match does not fire
      wr('h20, 1);
      wr('h7C, 'hE0);
      repeat (3) @(negedge clk);
      check("R11 disarmed no irq", int'(alarm_irq), 0);
      rd('h30, v); check("R11 status zero", v, 0);
      wr('h7C, 'hE1);
      @(negedge clk);
      check("R9 armed match fires", int'(alarm_irq), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule